// File: doc/BRIEF.md
# Conversion Result Output Port Formatter

This block sits between a converter core and a host. It holds the most recent 16-bit result and presents it either on a parallel bus or through a serial port. Static strap inputs choose the port type, the byte order on the parallel bus, and the output coding: straight binary, or twos complement made by flipping the top bit. Per-bit enables model the tri-state pins of the bus.

Results arrive on a valid/ready stream. A word is taken on any cycle where `res_valid` and `res_ready` are both high. `res_ready` stays high except while a serial transfer is loaded or running. During that time the source must hold `res_data` stable with `res_valid` asserted. There is no internal buffering.

In serial mode the port can run as a clock master or as a slave. As master it drives its own data clock, and that clock can be divided down. As slave it shifts on an external clock, and only while chip select is low. The block also reports busy and data-ready to the host.

Top module: `result_port_fmt`

## Requirements
- R1: With `straight_bin`=1 the word is presented unchanged. With `straight_bin`=0 bit 15 is inverted and bits 14:0 pass through. This gives twos complement.
- R2: With `swap_bytes`=0 the parallel bus carries the coded word as is. With `swap_bytes`=1 coded bits 7:0 appear on bus bits 15:8 and coded bits 15:8 appear on bus bits 7:0.
- R3: In parallel mode (`sel_serial`=0), `bus_oe` is 16'hFFFF while `cs_n`=0 and `rd_n`=0, and 16'h0003 otherwise.
- R4: In serial mode `bus_oe` is 16'h0003 whatever `cs_n` and `rd_n` are. Bus bits 1:0 are always driven.
- R5: In master mode (`clk_slave`=0) with `rd_after_conv`=1, the block starts clocking right after a result is accepted. `sclk_out` has a period of 2^(1+`div_sel`) clock cycles. Exactly 16 bits of the coded word go out, MSB first, with `sdata` changing only on falling `sclk_out`. `sclk_out` idles low. `sclk_oe`=1 in master mode.
- R6: In master mode with `rd_after_conv`=0, `div_sel` is ignored and the period is 2 cycles. A loaded word is not clocked out until the next `conv_start`.
- R7: In slave mode `sclk_oe`=0. `sdata` advances one bit per falling edge of `ext_sclk` seen while `cs_n`=0. Edges seen while `cs_n`=1 are ignored.
- R8: `busy` rises the cycle after `conv_start` and falls the cycle after a result is accepted. `data_ready` is set by an accepted result and cleared by `conv_start`.
- R9: `res_ready` is 0 from a serial load until its 16th shift, and 1 otherwise. In parallel mode it is always 1.
- R10: A synchronous reset clears the stored result to zero, stops any serial transfer, and clears `busy` and `data_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| conv_start | input | 1 | Conversion start pulse |
| res_valid | input | 1 | Result word valid |
| res_data | input | 16 | Raw conversion result |
| res_ready | output | 1 | Block can take a result |
| sel_serial | input | 1 | 0 parallel, 1 serial |
| swap_bytes | input | 1 | Byte lane exchange on bus |
| straight_bin | input | 1 | 1 straight binary, 0 twos complement |
| clk_slave | input | 1 | Serial clock source: 0 master, 1 external |
| rd_after_conv | input | 1 | Serial read after (1) or during (0) conversion |
| div_sel | input | 2 | Master clock divider selection |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Parallel read strobe, active low |
| ext_sclk | input | 1 | External serial clock |
| bus_out | output | 16 | Parallel bus data |
| bus_oe | output | 16 | Per-bit bus drive enable |
| sdata | output | 1 | Serial data |
| sclk_out | output | 1 | Master serial clock |
| sclk_oe | output | 1 | Master serial clock drive enable |
| busy | output | 1 | Conversion in progress |
| data_ready | output | 1 | New result held |

## Verification
The hardest state to reach is a master transfer in read-during-convert mode. The word must be loaded, and then the block must sit idle with `res_ready` low until a later `conv_start` releases the clock. The bench reaches it by first accepting a result with `rd_after_conv` low and `div_sel` at its slowest setting. It then watches for 20 cycles to confirm there are no clock edges. Only then does it pulse `conv_start`, and it checks that the clock runs at the undivided rate. Slave transfers are reached by toggling `ext_sclk` slowly enough to pass the input synchronizer, with one edge deliberately given while `cs_n` is high.

// File: rtl/fmt_pkg.sv
package fmt_pkg;
  parameter int DATA_W = 16;
  localparam int HALF_W = DATA_W / 2;

  function automatic logic [DATA_W-1:0] apply_coding(input logic [DATA_W-1:0] raw,
                                                     input logic straight);
    return straight ? raw : {~raw[DATA_W-1], raw[DATA_W-2:0]};
  endfunction

  function automatic logic [DATA_W-1:0] lane_swap(input logic [DATA_W-1:0] w,
                                                  input logic swap);
    return swap ? {w[HALF_W-1:0], w[DATA_W-1:HALF_W]} : w;
  endfunction
endpackage

// File: rtl/fmt_clkdiv.sv
module fmt_clkdiv #(
  parameter int DIV_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             sclk,
  output logic             fall_ev
);
  localparam int CNT_W = (1 << DIV_W) - 1;
  localparam logic [CNT_W:0] ONE = 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   half;
  logic [CNT_W-1:0] lim;

  always_comb begin
    half    = ONE << div;
    lim     = CNT_W'(half - ONE);
    fall_ev = run && (cnt == lim) && sclk;
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else if (cnt == lim) begin
      cnt  <= '0;
      sclk <= ~sclk;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R5: the clock only changes level when the divider count has wrapped
  a_r5_toggle_at_limit: assert property (@(posedge clk) disable iff (rst)
    (run && $past(run) && !$past(rst) && (sclk != $past(sclk))) |-> (cnt == '0));
endmodule

// File: rtl/fmt_edge_sync.sv
module fmt_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic fall_ev
);
  logic [STAGES:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) pipe <= '0;
    else     pipe <= {pipe[STAGES-1:0], async_in};
  end

  assign fall_ev = pipe[STAGES] && !pipe[STAGES-1];
endmodule

// File: rtl/fmt_shifter.sv
module fmt_shifter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_word,
  input  logic         shift_ev,
  output logic         sdata,
  output logic         active
);
  localparam int BC_W = $clog2(W);
  localparam logic [BC_W-1:0] LAST = BC_W'(W - 1);

  logic [W-1:0]    shreg;
  logic [BC_W-1:0] bit_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg   <= '0;
      bit_cnt <= '0;
      active  <= 1'b0;
    end else if (load) begin
      shreg   <= load_word;
      bit_cnt <= '0;
      active  <= 1'b1;
    end else if (active && shift_ev) begin
      shreg   <= {shreg[W-2:0], 1'b0};
      bit_cnt <= bit_cnt + 1'b1;
      if (bit_cnt == LAST) active <= 1'b0;
    end
  end

  assign sdata = shreg[W-1];

  // R5: serial data holds between shift events
  a_r5_data_holds: assert property (@(posedge clk) disable iff (rst)
    (!shift_ev && !load) |=> $stable(shreg));
  // R9: a transfer ends only on a shift event
  a_r9_end_on_shift: assert property (@(posedge clk) disable iff (rst)
    ($fell(active) && !$past(rst)) |-> $past(shift_ev));
endmodule

// File: rtl/result_port_fmt.sv
module result_port_fmt #(
  parameter int DATA_W = fmt_pkg::DATA_W,
  parameter int DIV_W  = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              conv_start,
  input  logic              res_valid,
  input  logic [DATA_W-1:0] res_data,
  output logic              res_ready,
  input  logic              sel_serial,
  input  logic              swap_bytes,
  input  logic              straight_bin,
  input  logic              clk_slave,
  input  logic              rd_after_conv,
  input  logic [DIV_W-1:0]  div_sel,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              ext_sclk,
  output logic [DATA_W-1:0] bus_out,
  output logic [DATA_W-1:0] bus_oe,
  output logic              sdata,
  output logic              sclk_out,
  output logic              sclk_oe,
  output logic              busy,
  output logic              data_ready
);
  import fmt_pkg::*;

  localparam int ALWAYS_ON = 2;
  localparam logic [DATA_W-1:0] BASE_OE = DATA_W'((1 << ALWAYS_ON) - 1);

  logic [DATA_W-1:0] result_q;
  logic              accept, load, active, go;
  logic              m_run, m_fall, s_fall, shift_ev;
  logic [DIV_W-1:0]  div_eff;

  assign res_ready = !active;
  assign accept    = res_valid && res_ready;
  assign load      = accept && sel_serial;

  always_ff @(posedge clk) begin
    if (rst) begin
      result_q   <= '0;
      busy       <= 1'b0;
      data_ready <= 1'b0;
      go         <= 1'b0;
    end else begin
      if (accept) result_q <= res_data;
      if (conv_start)  busy <= 1'b1;
      else if (accept) busy <= 1'b0;
      if (accept)          data_ready <= 1'b1;
      else if (conv_start) data_ready <= 1'b0;
      if (!active)         go <= 1'b0;
      else if (conv_start) go <= 1'b1;
    end
  end

  always_comb begin
    bus_out = lane_swap(apply_coding(result_q, straight_bin), swap_bytes);
    bus_oe  = (!sel_serial && !cs_n && !rd_n) ? '1 : BASE_OE;
  end

  assign div_eff  = rd_after_conv ? div_sel : '0;
  assign m_run    = active && !clk_slave && (rd_after_conv || go);
  assign shift_ev = clk_slave ? (s_fall && !cs_n) : m_fall;
  assign sclk_oe  = sel_serial && !clk_slave;

  fmt_clkdiv #(.DIV_W(DIV_W)) u_clkdiv (
    .clk(clk), .rst(rst), .run(m_run), .div(div_eff),
    .sclk(sclk_out), .fall_ev(m_fall)
  );

  fmt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(ext_sclk), .fall_ev(s_fall)
  );

  fmt_shifter #(.W(DATA_W)) u_shift (
    .clk(clk), .rst(rst), .load(load),
    .load_word(apply_coding(res_data, straight_bin)),
    .shift_ev(shift_ev), .sdata(sdata), .active(active)
  );

  // R8: busy clears only when a result was taken
  a_r8_busy_fall: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && !$past(rst)) |-> $past(res_valid && res_ready));
  // R8: data_ready sets only when a result was taken
  a_r8_ready_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(data_ready) |-> $past(res_valid && res_ready));
  // R6: read-during-convert master clock never runs before a start pulse
  a_r6_wait_start: assert property (@(posedge clk) disable iff (rst)
    (!clk_slave && !rd_after_conv && !go && !$past(go)) |-> !sclk_out);
endmodule

// File: tb/result_port_fmt_bench.sv
module result_port_fmt_bench;
  logic clk = 0, rst = 1, conv_start = 0, res_valid = 0;
  logic [15:0] res_data = '0;
  logic res_ready, sel_serial = 0, swap_bytes = 0, straight_bin = 1, clk_slave = 0;
  logic rd_after_conv = 1, cs_n = 1, rd_n = 1, ext_sclk = 0;
  logic [1:0] div_sel = '0;
  logic [15:0] bus_out, bus_oe;
  logic sdata, sclk_out, sclk_oe, busy, data_ready;
  int errors = 0, checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  result_port_fmt u_result_port_fmt (.*);

  // raw, swap, straight, expected bus
  localparam logic [33:0] VEC [7] = '{
    {16'h1234, 1'b0, 1'b1, 16'h1234},
    {16'h1234, 1'b0, 1'b0, 16'h9234},
    {16'h1234, 1'b1, 1'b1, 16'h3412},
    {16'h1234, 1'b1, 1'b0, 16'h3492},
    {16'hFFFF, 1'b0, 1'b0, 16'h7FFF},
    {16'h8000, 1'b1, 1'b0, 16'h0000},
    {16'h00A5, 1'b1, 1'b1, 16'hA500}
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic deliver(logic [15:0] d);
    @(negedge clk) conv_start = 1;
    @(negedge clk) conv_start = 0;
    chk("R8 busy rise", busy, 1);
    res_data = d; res_valid = 1;
    @(negedge clk) res_valid = 0;
    chk("R8 busy fall", busy, 0);
    chk("R8 data_ready", data_ready, 1);
  endtask

  task automatic collect(output logic [15:0] w, output int per);
    int n = 0, cyc = 0, r1 = -1, r2 = -1;
    logic prev = 0;
    w = '0;
    while (n < 16 && cyc < 2000) begin
      @(negedge clk); cyc++;
      if (sclk_out && !prev) begin
        w = {w[14:0], sdata}; n++;
        if (r1 < 0) r1 = cyc; else if (r2 < 0) r2 = cyc;
      end
      prev = sclk_out;
    end
    per = r2 - r1;
  endtask

  initial begin
    logic [15:0] w;
    int per, rises;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R10 reset state
    chk("R10 busy", busy, 0);
    chk("R10 data_ready", data_ready, 0);
    chk("R9 ready", res_ready, 1);

    // R1 R2 parallel vectors
    cs_n = 0; rd_n = 0;
    for (int i = 0; i < 7; i++) begin
      swap_bytes = VEC[i][17]; straight_bin = VEC[i][16];
      deliver(VEC[i][33:18]);
      chk("R1/R2 bus", bus_out, VEC[i][15:0]);
      chk("R3 oe read", bus_oe, 16'hFFFF);
    end
    cs_n = 1; @(negedge clk);
    chk("R3 oe cs high", bus_oe, 16'h0003);
    cs_n = 0; rd_n = 1; @(negedge clk);
    chk("R3 oe rd high", bus_oe, 16'h0003);
    rd_n = 0;

    // R5 master read-after-convert, all dividers
    sel_serial = 1; swap_bytes = 0; clk_slave = 0; rd_after_conv = 1;
    @(negedge clk);
    chk("R4 oe serial", bus_oe, 16'h0003);
    chk("R5 sclk_oe", sclk_oe, 1);
    for (int d = 0; d < 4; d++) begin
      div_sel = d[1:0]; straight_bin = d[0];
      deliver(16'hB38C);
      chk("R9 ready low", res_ready, 0);
      collect(w, per);
      chk("R5 word", w, d[0] ? 16'hB38C : 16'h338C);
      chk("R5 period", per, 2 << d);
      repeat (2 << d) @(negedge clk);
      chk("R5 idle low", sclk_out, 0);
      chk("R9 ready back", res_ready, 1);
    end

    // R6 read-during-convert
    rd_after_conv = 0; div_sel = 2'd3; straight_bin = 1;
    deliver(16'h5AC3);
    rises = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk); if (sclk_out) rises++;
    end
    chk("R6 no clock before start", rises, 0);
    chk("R9 ready held low", res_ready, 0);
    @(negedge clk) conv_start = 1;
    @(negedge clk) conv_start = 0;
    collect(w, per);
    chk("R6 word", w, 16'h5AC3);
    chk("R6 period", per, 2);
    res_data = 16'h0001; res_valid = 1;
    @(negedge clk) res_valid = 0;

    // R7 slave
    clk_slave = 1; rd_after_conv = 1; cs_n = 1;
    @(negedge clk);
    chk("R7 sclk_oe", sclk_oe, 0);
    deliver(16'hC3A9);
    ext_sclk = 1; repeat (4) @(negedge clk);
    ext_sclk = 0; repeat (6) @(negedge clk);
    cs_n = 0;
    w = '0;
    for (int b = 0; b < 16; b++) begin
      w = {w[14:0], sdata};
      ext_sclk = 1; repeat (4) @(negedge clk);
      ext_sclk = 0; repeat (6) @(negedge clk);
    end
    chk("R7 word", w, 16'hC3A9);
    chk("R9 ready after slave", res_ready, 1);

    // R10 reset during master transfer
    clk_slave = 0; div_sel = 2'd3; cs_n = 0; rd_n = 0;
    deliver(16'hFFFF);
    repeat (5) @(negedge clk);
    rst = 1; @(negedge clk); rst = 0;
    chk("R10 ready", res_ready, 1);
    chk("R10 busy", busy, 0);
    chk("R10 sclk", sclk_out, 0);
    chk("R10 data_ready", data_ready, 0);
    sel_serial = 0; @(negedge clk);
    chk("R10 result cleared", bus_out, 16'h0000);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule